// File: doc/BRIEF.md
# Path Remote Error Indication Counter

This block accumulates far-end error reports carried in the path status byte of one tributary. Each frame, an upstream framer hands over the status byte together with a one-cycle strobe. The block decodes the 4-bit remote error field in the upper nibble and adds it to a 16-bit running counter.

A configuration input sets what is added. In bit mode the decoded error count is added. In block mode one is added for each frame that reports any error. Field values above eight are not valid reports and contribute nothing.

At every performance-monitoring interval pulse, the running count is copied into a holding register and the counter restarts from zero. A one-cycle strobe tells the reader that the holding register has new contents. A second configuration input decides what happens when the counter is full: it either wraps around or sticks at all ones until the next interval clears it. One instance serves one tributary; a multi-tributary design places one instance per tributary.

Top module: `path_rei_counter`

## Requirements
- R1: While reset is asserted, and until the first interval pulse after reset, `hold_count` reads 0 and `hold_upd` reads 0.
- R2: In bit mode (`block_mode`=0), a strobed byte whose bits [7:4] hold a value from 0 to 8 adds that value to the running count. Bits [3:0] of the byte have no effect.
- R3: A strobed byte whose bits [7:4] hold 9 to 15 adds nothing, in either mode.
- R4: In block mode (`block_mode`=1), a strobed byte adds 1 when bits [7:4] hold 1 to 8, and adds 0 when they hold 0.
- R5: A byte presented while `byte_valid`=0 adds nothing.
- R6: An interval pulse (`pm_tick`=1) copies the running count into `hold_count` and clears the running count to 0.
  - If a strobed byte arrives in the same cycle as the pulse, its contribution is included in the copied value.
  - In that case the byte contributes nothing to the new count.
- R7: `hold_upd` is 1 in exactly the cycle after each interval pulse, and 0 otherwise.
  - `hold_count` shows its new value in that same cycle.
  - `hold_count` does not change in any cycle that does not follow an interval pulse.
- R8: With `sat_mode`=1, a sum that would exceed 16'hFFFF leaves the running count at 16'hFFFF.
- R9: With `sat_mode`=0, the running count wraps modulo 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| status_byte | input | 8 | Path status byte; bits [7:4] hold the error field |
| byte_valid | input | 1 | One-cycle strobe marking that `status_byte` is valid this frame |
| block_mode | input | 1 | 0: add the decoded error count; 1: add 1 per errored frame |
| sat_mode | input | 1 | 1: saturate at 16'hFFFF; 0: wrap around |
| pm_tick | input | 1 | Performance-monitoring interval pulse |
| hold_count | output | 16 | Count latched at the most recent interval pulse |
| hold_upd | output | 1 | One-cycle pulse when `hold_count` has been refreshed |

## Verification
A byte strobed in cycle N is added to the running count at the clock edge that ends cycle N. That count is not visible at the ports until an interval pulse, so every counting result is checked through `hold_count`.

A pulse in cycle N puts the latched value on `hold_count` and raises `hold_upd` at the edge ending cycle N. The bench therefore drives each cycle's inputs after a falling edge. It samples both outputs at the following falling edge and compares them with a model updated in the bench for that same cycle. This check is repeated every cycle, so a wrong latch value, a strobe landing a cycle early or late, or a holding register that drifts between pulses shows up in the cycle where it happens.

The saturation and wrap boundaries are reached by long directed runs of maximum-error frames.

// File: rtl/rei_pkg.sv
package rei_pkg;
  parameter int unsigned CNT_W     = 16;
  parameter int unsigned BYTE_W    = 8;
  parameter int unsigned CODE_W    = 4;
  parameter int unsigned CODE_LSB  = 4;
  parameter int unsigned CODE_MAX  = 8;
endpackage

// File: rtl/rei_rst_sync.sv
module rei_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/rei_decode.sv
module rei_decode #(
  parameter int unsigned BYTE_W   = rei_pkg::BYTE_W,
  parameter int unsigned CODE_W   = rei_pkg::CODE_W,
  parameter int unsigned CODE_LSB = rei_pkg::CODE_LSB,
  parameter int unsigned CODE_MAX = rei_pkg::CODE_MAX
) (
  input  logic [BYTE_W-1:0] status_byte,
  input  logic              byte_valid,
  input  logic              block_mode,
  output logic [CODE_W-1:0] inc,
  output logic              code_bad
);
  localparam logic [CODE_W-1:0] MAXV = CODE_W'(CODE_MAX);
  logic [CODE_W-1:0] code;
  logic [CODE_W-1:0] errs;

  always_comb begin
    code     = status_byte[CODE_LSB +: CODE_W];
    code_bad = (code > MAXV);
    errs     = code_bad ? '0 : code;
    if (!byte_valid)     inc = '0;
    else if (block_mode) inc = {{(CODE_W-1){1'b0}}, (errs != '0)};
    else                 inc = errs;
  end
endmodule

// File: rtl/rei_accum.sv
module rei_accum #(
  parameter int unsigned CNT_W  = rei_pkg::CNT_W,
  parameter int unsigned CODE_W = rei_pkg::CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] inc,
  input  logic              byte_valid,
  input  logic              pm_tick,
  input  logic              sat_mode,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [CNT_W-1:0]  cnt_nxt
);
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    sum     = {1'b0, cnt_q} + {{(CNT_W+1-CODE_W){1'b0}}, inc};
    cnt_nxt = (sat_mode && sum[CNT_W]) ? '1 : sum[CNT_W-1:0];
    cnt_en  = pm_tick | byte_valid;
    cnt_d   = pm_tick ? '0 : cnt_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_CLEAR_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    pm_tick |=> (cnt_q == '0)); // R6
  AST_SAT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_mode && (cnt_q == '1) && !pm_tick) |=> (cnt_q == '1)); // R8
  AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_valid && !pm_tick) |=> $stable(cnt_q)); // R5
endmodule

// File: rtl/rei_hold.sv
module rei_hold #(
  parameter int unsigned CNT_W = rei_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pm_tick,
  input  logic [CNT_W-1:0] latch_val,
  output logic [CNT_W-1:0] hold_count,
  output logic             hold_upd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_count <= '0;
    else if (pm_tick) hold_count <= latch_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_upd <= 1'b0;
    else        hold_upd <= pm_tick;
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pm_tick |=> $stable(hold_count)); // R7
  AST_UPD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    pm_tick |=> hold_upd); // R7
  AST_UPD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pm_tick |=> !hold_upd); // R7
endmodule

// File: rtl/path_rei_counter.sv
module path_rei_counter #(
  parameter int unsigned CNT_W    = rei_pkg::CNT_W,
  parameter int unsigned BYTE_W   = rei_pkg::BYTE_W,
  parameter int unsigned CODE_W   = rei_pkg::CODE_W,
  parameter int unsigned CODE_LSB = rei_pkg::CODE_LSB,
  parameter int unsigned CODE_MAX = rei_pkg::CODE_MAX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] status_byte,
  input  logic              byte_valid,
  input  logic              block_mode,
  input  logic              sat_mode,
  input  logic              pm_tick,
  output logic [CNT_W-1:0]  hold_count,
  output logic              hold_upd
);
  logic              rst_n_s;
  logic [CODE_W-1:0] inc;
  logic              code_bad;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_nxt;

  rei_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  rei_decode #(.BYTE_W(BYTE_W), .CODE_W(CODE_W), .CODE_LSB(CODE_LSB),
               .CODE_MAX(CODE_MAX)) u_dec (
    .status_byte(status_byte), .byte_valid(byte_valid),
    .block_mode(block_mode), .inc(inc), .code_bad(code_bad)
  );

  rei_accum #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_acc (
    .clk(clk), .rst_n(rst_n_s), .inc(inc), .byte_valid(byte_valid),
    .pm_tick(pm_tick), .sat_mode(sat_mode), .cnt_q(cnt_q), .cnt_nxt(cnt_nxt)
  );

  rei_hold #(.CNT_W(CNT_W)) u_hold (
    .clk(clk), .rst_n(rst_n_s), .pm_tick(pm_tick), .latch_val(cnt_nxt),
    .hold_count(hold_count), .hold_upd(hold_upd)
  );

  AST_BAD_CODE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n_s)
    (byte_valid && code_bad && !pm_tick) |=> $stable(cnt_q)); // R3
  AST_BLOCK_STEP: assert property (@(posedge clk) disable iff (!rst_n_s)
    (byte_valid && block_mode && !pm_tick && !sat_mode && (cnt_q != '1))
      |=> ((cnt_q - $past(cnt_q)) <= CNT_W'(1))); // R4
  AST_BIT_STEP: assert property (@(posedge clk) disable iff (!rst_n_s)
    (byte_valid && !pm_tick && !sat_mode && (cnt_q < CNT_W'(2**CNT_W - CODE_MAX - 1)))
      |=> ((cnt_q - $past(cnt_q)) <= CNT_W'(CODE_MAX))); // R2
endmodule

// File: tb/sim_path_rei_counter.sv
module sim_path_rei_counter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  status_byte;
  logic        byte_valid, block_mode, sat_mode, pm_tick;
  logic [15:0] hold_count;
  logic        hold_upd;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;
  logic [15:0] m_cnt;
  logic [15:0] m_hold;
  bit          done = 0;

  always #5 clk = ~clk;

  path_rei_counter u0 (
    .clk(clk), .rst_n(rst_n), .status_byte(status_byte), .byte_valid(byte_valid),
    .block_mode(block_mode), .sat_mode(sat_mode), .pm_tick(pm_tick),
    .hold_count(hold_count), .hold_upd(hold_upd)
  );

  function automatic logic [15:0] f_inc(logic [7:0] b, logic v, logic blk);
    logic [3:0] c = b[7:4];
    if (!v || c > 4'd8) return 16'd0;
    if (blk) return (c != 0) ? 16'd1 : 16'd0;
    return {12'd0, c};
  endfunction

  function automatic logic [15:0] f_add(logic [15:0] c, logic [15:0] i, logic sat);
    logic [16:0] s = {1'b0, c} + {1'b0, i};
    if (sat && s[16]) return 16'hFFFF;
    return s[15:0];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(logic [7:0] b, logic v, logic blk, logic sat, logic t, string tag);
    logic [15:0] nv;
    status_byte = b; byte_valid = v; block_mode = blk; sat_mode = sat; pm_tick = t;
    @(posedge clk);
    nv = f_add(m_cnt, f_inc(b, v, blk), sat);
    if (t) begin m_hold = nv; m_cnt = 16'd0; end
    else m_cnt = nv;
    @(negedge clk);
    check({tag, " hold_count"}, {16'd0, hold_count}, {16'd0, m_hold});
    check("R7 hold_upd", {31'd0, hold_upd}, {31'd0, t});
  endtask

  task automatic idle_tick(string tag);
    step(8'h00, 1'b0, 1'b0, 1'b0, 1'b1, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; status_byte = 8'h00; byte_valid = 1'b0; block_mode = 1'b0;
    sat_mode = 1'b0; pm_tick = 1'b0;
    m_cnt = 16'd0; m_hold = 16'd0;
    repeat (3) @(negedge clk);
    check("R1 reset hold_count", {16'd0, hold_count}, 32'd0);
    check("R1 reset hold_upd", {31'd0, hold_upd}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", {16'd0, hold_count}, 32'd0);

    // R2: bit mode codes 0..8 with random low nibble
    for (int c = 0; c <= 8; c++) step({c[3:0], 4'($urandom)}, 1'b1, 1'b0, 1'b0, 1'b0, "R2");
    idle_tick("R2 sum 36");
    check("R2 latched 36", {16'd0, hold_count}, 32'd36);

    // R3: codes 9..15 in both modes
    for (int c = 9; c <= 15; c++) begin
      step({c[3:0], 4'hF}, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
      step({c[3:0], 4'h0}, 1'b1, 1'b1, 1'b0, 1'b0, "R3");
    end
    idle_tick("R3 zero");
    check("R3 latched 0", {16'd0, hold_count}, 32'd0);

    // R4: block mode
    step(8'h00, 1'b1, 1'b1, 1'b0, 1'b0, "R4");
    step(8'h10, 1'b1, 1'b1, 1'b0, 1'b0, "R4");
    step(8'h8F, 1'b1, 1'b1, 1'b0, 1'b0, "R4");
    step(8'h55, 1'b1, 1'b1, 1'b0, 1'b0, "R4");
    idle_tick("R4 count 3");
    check("R4 latched 3", {16'd0, hold_count}, 32'd3);

    // R5: bytes without strobe
    for (int i = 0; i < 5; i++) step(8'h80, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
    idle_tick("R5 zero");
    check("R5 latched 0", {16'd0, hold_count}, 32'd0);

    // R6: same-cycle byte and pulse, then fresh count
    step(8'h30, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
    step(8'h50, 1'b1, 1'b0, 1'b0, 1'b1, "R6 same cycle");
    check("R6 latched 8", {16'd0, hold_count}, 32'd8);
    step(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R7 stable");
    idle_tick("R6 cleared");
    check("R6 restart 0", {16'd0, hold_count}, 32'd0);
    idle_tick("R7 back-to-back");

    // R8: saturation
    for (int i = 0; i < 8200; i++) step(8'h80, 1'b1, 1'b0, 1'b1, 1'b0, "R8");
    idle_tick("R8 sat");
    check("R8 latched FFFF", {16'd0, hold_count}, 32'hFFFF);

    // R9: wrap
    for (int i = 0; i < 8193; i++) step(8'h80, 1'b1, 1'b0, 1'b0, 1'b0, "R9");
    idle_tick("R9 wrap");
    check("R9 latched 8", {16'd0, hold_count}, 32'd8);

    // random mix (R2..R7)
    for (int seg = 0; seg < 20; seg++) begin
      logic blk = 1'($urandom);
      logic sat = 1'($urandom);
      for (int i = 0; i < 200; i++)
        step(8'($urandom), ($urandom % 2) == 0, blk, sat, ($urandom % 40) == 0, "R6 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule